// File: doc/BRIEF.md
# Vector element predicate sequencer

This block steps through the elements of a single vector operation and tells the execution pipeline, one element slot per clock, whether that slot may write its destination and whether it may read its source. An operation is launched with a vector length and a sub-vector length code. The sequencer then emits every sub-element of every element in ascending order. Elements that are masked off are still emitted, with their enable low, so that downstream logic can keep count of the index.

Predicates come from one of two places, selected by a single mode bit. In integer mode a 3-bit selector picks an all-ones mask, a one-hot match against the index, or bit i (true or inverted) of one of three integer registers. These registers are captured when the operation is accepted. In condition-field mode the same selector picks one of four flag bits, true or inverted, from the condition field that belongs to the current element. That field is fetched through a read port in the slot where it is needed. An optional second selector, in the same mode, gives an independent source mask. A vector length of zero completes at once without emitting anything.

Top module: `pred_seq`

## Requirements
- R1: After reset, `busy`, `elem_valid` and `done` are low, and `elem_valid` stays low while no operation is running.
- R2: A `start` while idle with `vl` greater than zero makes `elem_valid` high in the following cycle with element 0, sub-element 0. Slots then advance one per cycle, sub-element first, for `vl` times (`subvl`+1) cycles. A `vl` above 64 is treated as 64.
- R3: `subvl` codes 0, 1, 2 and 3 give 1, 2, 3 and 4 sub-elements per element (`sub_idx` counts 0 upward), and every sub-element of an element carries the same enables.
- R4: With `mask_mode`=0, selector values map as follows. 0 enables all elements. 1 enables only element i where the captured r3 value equals i. 2 and 3 use bit i of r3, set and clear respectively. 4 and 5 do the same with r10, and 6 and 7 with r30.
- R5: With `mask_mode`=1, each slot of element i drives `cr_rd_en` high and `cr_rd_idx` = 32+i. The returned 4-bit field holds LT at bit 3, GT at bit 2, EQ at bit 1 and SO at bit 0. Selector bits [2:1] pick LT, GT, EQ or SO for values 0, 1, 2 and 3, and selector bit 0 set means the flag must be clear. In integer mode `cr_rd_en` is low.
- R6: With `twin`=1, `src_en` is decoded from `src_sel` exactly as `dst_en` is from `dst_sel`, in the same mode. With `twin`=0, `src_en` equals `dst_en`.
- R7: The three integer register values, the selectors, the mode and the lengths are captured at the accepted `start`. Later changes on those inputs do not alter the running operation.
- R8: A `start` while idle with `vl`=0 emits no slot and raises `done` for one cycle in the next cycle.
- R9: `done` is high for exactly the one cycle after the last slot, and `busy` is low in that cycle.
- R10: A `start` while `busy` is ignored, so the running operation's length and masks are unchanged.
- R11: Elements whose destination enable is 0 are still emitted with `elem_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken only while idle |
| vl | input | 7 | Vector length, saturated at 64 |
| subvl | input | 2 | Sub-vector length code (n-1) |
| mask_mode | input | 1 | 0 integer predication, 1 condition-field predication |
| dst_sel | input | 3 | Destination mask selector |
| twin | input | 1 | Use independent source mask |
| src_sel | input | 3 | Source mask selector |
| r3_val | input | 64 | Integer predicate register r3 |
| r10_val | input | 64 | Integer predicate register r10 |
| r30_val | input | 64 | Integer predicate register r30 |
| cr_rd_en | output | 1 | Condition-field read request |
| cr_rd_idx | output | 7 | Condition-field number to read |
| cr_rd_data | input | 4 | Field returned in the same cycle (LT,GT,EQ,SO) |
| busy | output | 1 | Operation in progress |
| elem_valid | output | 1 | A slot is presented this cycle |
| elem_idx | output | 6 | Element index of the slot |
| sub_idx | output | 2 | Sub-element index of the slot |
| dst_en | output | 1 | Destination write enable for the slot |
| src_en | output | 1 | Source read enable for the slot |
| done | output | 1 | One-cycle pulse when the operation completes |

## Verification
The embedded properties assume that reset is asserted from time zero. They also assume that `cr_rd_data` is a combinational reply to `cr_rd_idx` in the same cycle. The stimulus meets both conditions: it holds reset for several cycles and models the condition-field store as a pure function of the requested index. It drives every input only on the falling edge, and it deliberately changes the captured inputs and raises `start` in the middle of each run. Lengths stay within the port width, and one case exceeds 64 to exercise saturation.

// File: rtl/pred_seq.sv
module pred_seq #(
  parameter int MAXVL  = 64,
  parameter int REGW   = 64,
  parameter int CRBASE = 32,
  parameter int CRW    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [$clog2(MAXVL):0]     vl,
  input  logic [1:0]                 subvl,
  input  logic                       mask_mode,
  input  logic [2:0]                 dst_sel,
  input  logic                       twin,
  input  logic [2:0]                 src_sel,
  input  logic [REGW-1:0]            r3_val,
  input  logic [REGW-1:0]            r10_val,
  input  logic [REGW-1:0]            r30_val,
  output logic                       cr_rd_en,
  output logic [CRW-1:0]             cr_rd_idx,
  input  logic [3:0]                 cr_rd_data,
  output logic                       busy,
  output logic                       elem_valid,
  output logic [$clog2(MAXVL)-1:0]   elem_idx,
  output logic [1:0]                 sub_idx,
  output logic                       dst_en,
  output logic                       src_en,
  output logic                       done
);
  localparam int IW = $clog2(MAXVL);
  localparam int VW = IW + 1;

  logic            busy_q, done_q, mode_q, twin_q;
  logic [IW-1:0]   idx_q, last_q;
  logic [1:0]      sub_q, subvl_q;
  logic [2:0]      dsel_q, ssel_q;
  logic [REGW-1:0] r3_q, r10_q, r30_q;
  logic [VW-1:0]   vl_sat;

  assign vl_sat = (vl > VW'(MAXVL)) ? VW'(MAXVL) : vl;

  function automatic logic int_pred(input logic [2:0] sel, input logic [IW-1:0] i,
                                    input logic [REGW-1:0] a, b, c);
    case (sel[2:1])
      2'd0:    int_pred = sel[0] ? (a == REGW'(i)) : 1'b1;
      2'd1:    int_pred = a[i] ^ sel[0];
      2'd2:    int_pred = b[i] ^ sel[0];
      default: int_pred = c[i] ^ sel[0];
    endcase
  endfunction

  function automatic logic cr_pred(input logic [2:0] sel, input logic [3:0] f);
    cr_pred = f[~sel[2:1]] ^ sel[0];
  endfunction

  logic d_pred, s_pred;
  assign d_pred = mode_q ? cr_pred(dsel_q, cr_rd_data) : int_pred(dsel_q, idx_q, r3_q, r10_q, r30_q);
  assign s_pred = mode_q ? cr_pred(ssel_q, cr_rd_data) : int_pred(ssel_q, idx_q, r3_q, r10_q, r30_q);

  assign busy       = busy_q;
  assign elem_valid = busy_q;
  assign elem_idx   = idx_q;
  assign sub_idx    = sub_q;
  assign done       = done_q;
  assign cr_rd_en   = busy_q & mode_q;
  assign cr_rd_idx  = CRW'(CRBASE) + CRW'(idx_q);
  assign dst_en     = busy_q & d_pred;
  assign src_en     = busy_q & (twin_q ? s_pred : d_pred);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      sub_q   <= '0;
      last_q  <= '0;
      subvl_q <= '0;
      mode_q  <= 1'b0;
      twin_q  <= 1'b0;
      dsel_q  <= '0;
      ssel_q  <= '0;
      r3_q    <= '0;
      r10_q   <= '0;
      r30_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          last_q  <= IW'(vl_sat - VW'(1));
          subvl_q <= subvl;
          mode_q  <= mask_mode;
          twin_q  <= twin;
          dsel_q  <= dst_sel;
          ssel_q  <= src_sel;
          r3_q    <= r3_val;
          r10_q   <= r10_val;
          r30_q   <= r30_val;
          idx_q   <= '0;
          sub_q   <= '0;
          if (vl_sat == '0) done_q <= 1'b1;
          else              busy_q <= 1'b1;
        end
      end else if (sub_q == subvl_q) begin
        sub_q <= '0;
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end else begin
        sub_q <= sub_q + 2'd1;
      end
    end
  end

  assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (idx_q == '0 && sub_q == '0));

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= last_q && sub_q <= subvl_q));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(last_q) && $stable(dsel_q) && $stable(r3_q)));

  assert_no_regress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (idx_q > $past(idx_q) || (idx_q == $past(idx_q) && sub_q == $past(sub_q) + 2'd1)));

  assert_sub_share_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sub_q != '0 && !mode_q) |-> (dst_en == $past(dst_en)));
endmodule

// File: tb/sim_pred_seq.sv
module sim_pred_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [1:0]  subvl = '0;
  logic        mask_mode = 1'b0;
  logic [2:0]  dst_sel = '0;
  logic        twin = 1'b0;
  logic [2:0]  src_sel = '0;
  logic [63:0] r3_val = '0, r10_val = '0, r30_val = '0;
  logic        cr_rd_en;
  logic [6:0]  cr_rd_idx;
  logic [3:0]  cr_rd_data;
  logic        busy, elem_valid, dst_en, src_en, done;
  logic [5:0]  elem_idx;
  logic [1:0]  sub_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pred_seq u0 (.clk, .rst_n, .start, .vl, .subvl, .mask_mode, .dst_sel, .twin, .src_sel,
               .r3_val, .r10_val, .r30_val, .cr_rd_en, .cr_rd_idx, .cr_rd_data,
               .busy, .elem_valid, .elem_idx, .sub_idx, .dst_en, .src_en, .done);

  function automatic logic [3:0] cr_model(input logic [6:0] n);
    cr_model = 4'(n * 7'd5) ^ 4'(n >> 3);
  endfunction
  assign cr_rd_data = cr_model(cr_rd_idx);

  typedef struct packed {
    logic        mode;
    logic [2:0]  dsel;
    logic        tw;
    logic [2:0]  ssel;
    logic [6:0]  len;
    logic [1:0]  sv;
    logic [63:0] a, b, c;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 1'b0, 3'd0, 7'd4,   2'd0, 64'h0, 64'h0, 64'h0},
    '{1'b0, 3'd1, 1'b0, 3'd0, 7'd5,   2'd1, 64'd2, 64'h0, 64'h0},
    '{1'b0, 3'd2, 1'b0, 3'd0, 7'd8,   2'd0, 64'hA5, 64'h0, 64'h0},
    '{1'b0, 3'd3, 1'b0, 3'd0, 7'd8,   2'd2, 64'hA5, 64'h0, 64'h0},
    '{1'b0, 3'd4, 1'b0, 3'd0, 7'd20,  2'd0, 64'h0, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0},
    '{1'b0, 3'd5, 1'b1, 3'd6, 7'd16,  2'd3, 64'h0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_3C3C_5555_AAAA},
    '{1'b0, 3'd7, 1'b0, 3'd0, 7'd64,  2'd0, 64'h0, 64'h0, 64'h8000_0000_0000_0001},
    '{1'b1, 3'd0, 1'b0, 3'd0, 7'd10,  2'd0, 64'h0, 64'h0, 64'h0},
    '{1'b1, 3'd3, 1'b1, 3'd4, 7'd12,  2'd1, 64'h0, 64'h0, 64'h0},
    '{1'b1, 3'd6, 1'b1, 3'd7, 7'd9,   2'd2, 64'h0, 64'h0, 64'h0},
    '{1'b1, 3'd5, 1'b0, 3'd0, 7'd100, 2'd0, 64'h0, 64'h0, 64'h0},
    '{1'b0, 3'd1, 1'b1, 3'd2, 7'd6,   2'd0, 64'h1_0000_0000, 64'h0, 64'h0}
  };

  function automatic logic exp_pred(input logic m, input logic [2:0] s, input int e,
                                    input logic [63:0] a, b, c);
    logic [3:0] f;
    logic flag;
    if (m) begin
      f = cr_model(7'(32 + e));
      case (s[2:1])
        2'd0: flag = f[3];
        2'd1: flag = f[2];
        2'd2: flag = f[1];
        default: flag = f[0];
      endcase
      exp_pred = s[0] ? !flag : flag;
    end else begin
      case (s)
        3'd0: exp_pred = 1'b1;
        3'd1: exp_pred = (a == 64'(e));
        3'd2: exp_pred = a[e];
        3'd3: exp_pred = !a[e];
        3'd4: exp_pred = b[e];
        3'd5: exp_pred = !b[e];
        3'd6: exp_pred = c[e];
        default: exp_pred = !c[e];
      endcase
    end
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int n;
    logic de, se;
    logic [63:0] act, exp;
    mask_mode = v.mode; dst_sel = v.dsel; twin = v.tw; src_sel = v.ssel;
    vl = v.len; subvl = v.sv; r3_val = v.a; r10_val = v.b; r30_val = v.c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = (v.len > 7'd64) ? 64 : int'(v.len);
    for (int e = 0; e < n; e++) begin
      de = exp_pred(v.mode, v.dsel, e, v.a, v.b, v.c);
      se = v.tw ? exp_pred(v.mode, v.ssel, e, v.a, v.b, v.c) : de;
      for (int s = 0; s <= int'(v.sv); s++) begin
        act = {40'd0, elem_valid, elem_idx, sub_idx, dst_en, src_en, cr_rd_en, (v.mode ? cr_rd_idx : 7'd0)};
        exp = {40'd0, 1'b1, 6'(e), 2'(s), de, se, v.mode, (v.mode ? 7'(32 + e) : 7'd0)};
        chk(act == exp, v.mode ? "R5/R2/R3/R6/R7/R10/R11" : "R4/R2/R3/R6/R7/R10/R11", act, exp);
        if (e == 0 && s == 0) begin
          r3_val = ~v.a; r10_val = ~v.b; r30_val = ~v.c;
          vl = 7'd3; subvl = ~v.sv; mask_mode = ~v.mode; dst_sel = ~v.dsel; twin = ~v.tw;
          start = 1'b1;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(done && !busy && !elem_valid, "R9 done after last slot", {busy, elem_valid, done}, 64'b001);
    @(negedge clk);
    chk(!done && !elem_valid, "R9 done one cycle", {elem_valid, done}, 64'b00);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !elem_valid && !done, "R1 reset state", {busy, elem_valid, done}, 64'd0);
    repeat (3) @(negedge clk);
    chk(!elem_valid && !busy, "R1 idle without start", {busy, elem_valid}, 64'd0);

    for (int k = 0; k < NV; k++) run(TBL[k]);

    vl = 7'd0; mask_mode = 1'b0; dst_sel = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !elem_valid && !busy, "R8 zero length", {busy, elem_valid, done}, 64'b001);
    @(negedge clk);
    chk(!done && !elem_valid, "R8 zero length pulse", {elem_valid, done}, 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule